// File: doc/BRIEF.md
# Serial Hold Condition Gate

This block sits beside the command engine of a serial memory slave and decides when the serial link is paused. The bus pins (active-low select, active-low hold request and the serial clock) come in already synchronised to a faster system clock. The block turns the serial clock into two one-cycle shift strobes. It masks those strobes while a pause is in force. It also drives an override that tri-states the serial data output. The engine's bit counter and shift register are advanced only by the strobes, so they keep their contents across a pause and the transfer resumes at the same bit.

A pause begins or ends only while the serial clock is low. A change of the hold request made while the clock is high takes effect once the clock is next sampled low. Raising select during a pause raises an abort line, which the engine uses to drop the transaction in progress, and the pause itself clears.

Top module: `serial_hold_gate`

## Requirements
- R1: After reset, `hold_active`, `shift_in_en`, `shift_out_en` and `xact_abort` are 0, and the stored clock sample is 0.
- R2: If `sel_n`=0, `hold_n`=0 and `sck`=0 are sampled at a rising `clk` edge, `hold_active` is 1 from that edge on.
- R3: A low `hold_n` sampled together with `sck`=1 does not set `hold_active`; entry waits for the first edge where `sck` is sampled 0.
- R4: While held, an edge that samples `hold_n`=1, `sck`=0 and `sel_n`=0 clears `hold_active`; with `sck`=1 the pause persists.
- R5: When not held and `sel_n`=0, `shift_in_en` is 1 in the cycle where `sck` is 1 and the previous sample was 0, and `shift_out_en` is 1 in the cycle where `sck` is 0 and the previous sample was 1. Otherwise both are 0.
- R6: While `hold_active` is 1, both shift strobes stay 0 whatever `sck` does.
- R7: `q_oe_block` is 1 exactly when `hold_active` is 1 or `sel_n` is 1.
- R8: `xact_abort` is 1 in a cycle where `hold_active` is 1 and `sel_n` is 1, and `hold_active` is 0 after that edge.
- R9: With `sel_n`=1, no combination of `hold_n` and `sck` sets `hold_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Synchronised active-low select |
| hold_n | input | 1 | Synchronised active-low pause request |
| sck | input | 1 | Synchronised serial clock |
| hold_active | output | 1 | Pause in force |
| shift_in_en | output | 1 | One-cycle strobe on a qualified rising serial clock |
| shift_out_en | output | 1 | One-cycle strobe on a qualified falling serial clock |
| q_oe_block | output | 1 | Forces the serial data output to high impedance |
| xact_abort | output | 1 | Transaction reset request: deselected while held |

## Verification
Directed sequences separate the two qualifying paths: a hold request dropped with the clock high must wait for the clock to fall, and released with the clock high must also wait. Random mixes of clock toggles, hold changes and rare deselects show whether strobes leak through a pause. They also show whether a deselect inside a pause raises the abort line and clears the state, as against a deselect outside a pause, which must not raise it. Every cycle compares all five outputs with a bench model.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;
  typedef enum logic {
    HG_RUN  = 1'b0,
    HG_HELD = 1'b1
  } hg_state_e;
endpackage

// File: rtl/sck_edge_det.sv
module sck_edge_det #(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_LEVEL;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
endmodule

// File: rtl/hold_state_ctl.sv
module hold_state_ctl
  import hold_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic hold_n,
  input  logic sck,
  output logic held,
  output logic abort
);
  hg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (sel_n) begin
      state_d = HG_RUN;
    end else if (!sck) begin
      // only a low serial clock lets the pause state move
      case (state_q)
        HG_RUN:  if (!hold_n) state_d = HG_HELD;
        HG_HELD: if (hold_n)  state_d = HG_RUN;
        default: state_d = HG_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HG_RUN;
    else        state_q <= state_d;
  end

  assign held  = (state_q == HG_HELD);
  assign abort = held & sel_n;
endmodule

// File: rtl/serial_hold_gate.sv
module serial_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic hold_n,
  input  logic sck,
  output logic hold_active,
  output logic shift_in_en,
  output logic shift_out_en,
  output logic q_oe_block,
  output logic xact_abort
);
  logic sck_rise, sck_fall;
  logic held;
  logic pass;

  sck_edge_det #(.RESET_LEVEL(1'b0)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (sck),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  hold_state_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (sel_n),
    .hold_n(hold_n),
    .sck   (sck),
    .held  (held),
    .abort (xact_abort)
  );

  assign pass         = ~held & ~sel_n;
  assign shift_in_en  = pass & sck_rise;
  assign shift_out_en = pass & sck_fall;
  assign hold_active  = held;
  assign q_oe_block   = held | sel_n;
endmodule

// File: rtl/serial_hold_gate_chk.sv
module serial_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic hold_n,
  input logic sck,
  input logic hold_active,
  input logic shift_in_en,
  input logic shift_out_en,
  input logic q_oe_block,
  input logic xact_abort
);
  // R2
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !hold_n && !sck) |=> hold_active);
  // R3
  defer_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_active && sck) |=> !hold_active);
  // R4
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && hold_n && !sck) |=> !hold_active);
  // R4
  defer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && sck && !sel_n) |=> hold_active);
  // R6
  no_shift_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!shift_in_en && !shift_out_en));
  // R7
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active || sel_n) |-> q_oe_block);
  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xact_abort |=> !hold_active);
  // R9
  no_entry_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !hold_active);
endmodule

bind serial_hold_gate serial_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .hold_n(hold_n), .sck(sck),
  .hold_active(hold_active), .shift_in_en(shift_in_en),
  .shift_out_en(shift_out_en), .q_oe_block(q_oe_block),
  .xact_abort(xact_abort)
);

// File: tb/serial_hold_gate_tb_top.sv
module serial_hold_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, hold_n = 1'b1, sck = 1'b0;
  logic hold_active, shift_in_en, shift_out_en, q_oe_block, xact_abort;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit m_held = 1'b0;
  bit m_prev = 1'b0;

  always #5 clk = ~clk;

  serial_hold_gate dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .hold_n(hold_n), .sck(sck),
    .hold_active(hold_active), .shift_in_en(shift_in_en),
    .shift_out_en(shift_out_en), .q_oe_block(q_oe_block),
    .xact_abort(xact_abort)
  );

  function automatic bit next_held(bit h, bit s, bit hn, bit c);
    if (s) return 1'b0;
    if (!c && !h && !hn) return 1'b1;
    if (!c && h && hn) return 1'b0;
    return h;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(bit s, bit hn, bit c);
    bit pass;
    @(negedge clk);
    sel_n = s; hold_n = hn; sck = c;
    #1;
    pass = !m_held && !s;
    chk("R2/R3/R4", "hold_active", hold_active, m_held);
    chk("R5/R6", "shift_in_en", shift_in_en, pass && c && !m_prev);
    chk("R5/R6", "shift_out_en", shift_out_en, pass && !c && m_prev);
    chk("R7", "q_oe_block", q_oe_block, m_held || s);
    chk("R8", "xact_abort", xact_abort, m_held && s);
    @(posedge clk);
    m_held = next_held(m_held, s, hn, c);
    m_prev = c;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit s, hn, c;
    void'($urandom(32'd1234));
    #12;
    // R1: reset state
    chk("R1", "hold_active", hold_active, 1'b0);
    chk("R1", "xact_abort", xact_abort, 1'b0);
    chk("R1", "shift strobes", shift_in_en | shift_out_en, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    // R5: plain shifting, two clock periods
    step(0,1,0); step(0,1,1); step(0,1,1); step(0,1,0); step(0,1,1); step(0,1,0);
    // R3: request with clock high waits for clock low
    step(0,0,1); step(0,0,1); step(0,0,1); step(0,0,0); step(0,0,0);
    // R6: clock toggles while held
    step(0,0,1); step(0,0,0); step(0,0,1);
    // R4: release with clock high persists, clears once low
    step(0,1,1); step(0,1,1); step(0,1,0); step(0,1,0); step(0,1,1);
    // R8: deselect while held
    step(0,1,0); step(0,0,0); step(0,0,0); step(1,0,0); step(1,0,0);
    // R9: deselected, hold request low, clock low: no entry
    step(1,0,0); step(1,0,1); step(1,0,0);
    step(0,1,0); step(0,1,0);
    // random mix
    s = 0; hn = 1; c = 0;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 2) == 0) c = ~c;
      if (($urandom % 8) == 0) hn = ~hn;
      s = (($urandom % 24) == 0);
      step(s, hn, c);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule